// File: doc/BRIEF.md
# RAM-Based Selectable-Tap Delay Line

This block is a byte-wide delay line that takes in one sample on every rising clock edge. A tap index picks which past sample drives the output. To the logic around it, the block looks like a long shift register with a movable output tap. The samples never move, though. They sit in an inferred simple dual-port memory.

A circular write position stores each new sample and then steps forward. The read side turns the tap index into an offset behind that position. The read is registered, so the storage maps onto block memory. A line of a few hundred entries therefore costs one memory and two small adders instead of thousands of flip-flops.

The line length is a parameter. The memory depth is that length rounded up to the next power of two, so both addresses wrap with no extra logic. Reset returns the write position to the start and leaves the stored data in place.

Top module: `tdl_tap_line`

## Requirements
- R1: Once running, the block stores `sample_i` on every rising edge. After edge N, `sample_o` shows the sample accepted on edge N-1-t, where t is the tap presented before edge N. Tap 0 is therefore the sample taken on the edge before, and the output lags the tap by one registered cycle.
- R2: The write position steps by one on every running edge. It wraps modulo DEPTH, the smallest power of two not below LINE_LEN. Results stay correct across any number of wraps.
- R3: The tap input is $clog2(LINE_LEN) bits wide. A tap value of LINE_LEN or more acts exactly like tap LINE_LEN-1.
- R4: All eight output bits come from one memory word chosen by the single tap index. No bit lane is taken from a different sample.
- R5: `rst_ni` is asynchronous and active low. It forces `sample_o` to zero at once. The internal reset releases on the second rising edge after `rst_ni` rises, and the output stays zero through that edge. The first sample after reset is stored on the third edge, at address 0.
- R6: Reset leaves the memory contents unchanged. A tap that reaches past the samples taken since reset returns the word stored at address (-1-t) mod DEPTH before the reset.
- R7: When LINE_LEN equals DEPTH, the deepest tap reads the address being written on the same edge. It returns the old word there, which is the sample from DEPTH edges earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one sample per rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sample_i | input | DATA_W | New sample entering the line |
| tap_i | input | $clog2(LINE_LEN) | Tap index; 0 is the newest sample |
| sample_o | output | DATA_W | Registered sample at the selected tap |

## Verification
The bench builds two copies side by side. One has LINE_LEN = 20. Its memory is 32 deep, so tap values 20 to 31 reach the clamp and the write position wraps often. The other has LINE_LEN = 16, which fills its memory exactly. There the deepest tap lands on the address being written, which exercises the read-before-write case. A reset in the middle of a run, with both memories already full, shows that the stored words survive reset while the write position restarts.

// File: rtl/tdl_pkg.sv
package tdl_pkg;

  // Smallest power of two that is not below n (n >= 2).
  function automatic int unsigned pow2_at_least(input int unsigned n);
    int unsigned p;
    p = 1;
    while (p < n) p = p * 2;
    return p;
  endfunction

  // Address width for a line of n entries.
  function automatic int unsigned addr_bits(input int unsigned n);
    return $clog2(pow2_at_least(n));
  endfunction

endpackage

// File: rtl/tdl_rst_sync.sv
module tdl_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) chain_q <= '0;
    else          chain_q <= chain_d;
  end

  assign rst_no = chain_q[STAGES-1];

endmodule

// File: rtl/tdl_wr_ctr.sv
module tdl_wr_ctr #(
  parameter int unsigned AW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  output logic [AW-1:0] ptr_o
);

  logic [AW-1:0] ptr_q;
  logic [AW-1:0] ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (en_i) ptr_d = ptr_q + AW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else         ptr_q <= ptr_d;
  end

  assign ptr_o = ptr_q;

  AST_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> (ptr_o == $past(ptr_o) + AW'(1)));  // R2

endmodule

// File: rtl/tdl_rd_addr.sv
module tdl_rd_addr #(
  parameter int unsigned LINE_LEN = 500,
  parameter int unsigned TAP_W    = 9,
  parameter int unsigned AW       = 9
) (
  input  logic [AW-1:0]    wptr_i,
  input  logic [TAP_W-1:0] tap_i,
  output logic [AW-1:0]    raddr_o
);

  localparam logic [TAP_W-1:0] LAST_TAP = TAP_W'(LINE_LEN - 1);

  logic [TAP_W-1:0] tap_lim;

  always_comb begin
    tap_lim = tap_i;
    if (tap_i > LAST_TAP) tap_lim = LAST_TAP;
  end

  always_comb begin
    raddr_o = wptr_i - AW'(1) - AW'(tap_lim);
  end

endmodule

// File: rtl/tdl_sdp_ram.sv
module tdl_sdp_ram #(
  parameter int unsigned DW    = 8,
  parameter int unsigned AW    = 9,
  parameter int unsigned DEPTH = 512
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);

  logic [DW-1:0] store [DEPTH];
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk_i) begin
    if (we_i) store[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= store[raddr_i];
  end

  assign rdata_o = rdata_q;

endmodule

// File: rtl/tdl_tap_line.sv
module tdl_tap_line
  import tdl_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned LINE_LEN    = 500,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned TAP_W      = $clog2(LINE_LEN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] sample_i,
  input  logic [TAP_W-1:0]  tap_i,
  output logic [DATA_W-1:0] sample_o
);

  localparam int unsigned DEPTH = pow2_at_least(LINE_LEN);
  localparam int unsigned AW    = addr_bits(LINE_LEN);
  localparam logic [TAP_W-1:0] LAST_TAP = TAP_W'(LINE_LEN - 1);

  logic          run_n;
  logic [AW-1:0] wptr;
  logic [AW-1:0] raddr;
  logic [AW:0]   span;

  tdl_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_i   (clk_i),
    .arst_ni (rst_ni),
    .rst_no  (run_n)
  );

  tdl_wr_ctr #(.AW(AW)) u_wr_ctr (
    .clk_i  (clk_i),
    .rst_ni (run_n),
    .en_i   (run_n),
    .ptr_o  (wptr)
  );

  tdl_rd_addr #(.LINE_LEN(LINE_LEN), .TAP_W(TAP_W), .AW(AW)) u_rd_addr (
    .wptr_i  (wptr),
    .tap_i   (tap_i),
    .raddr_o (raddr)
  );

  tdl_sdp_ram #(.DW(DATA_W), .AW(AW), .DEPTH(DEPTH)) u_ram (
    .clk_i   (clk_i),
    .rst_ni  (run_n),
    .we_i    (run_n),
    .waddr_i (wptr),
    .wdata_i (sample_i),
    .re_i    (run_n),
    .raddr_i (raddr),
    .rdata_o (sample_o)
  );

  // Distance from the read address back to the write position, 1..DEPTH.
  always_comb begin
    span = {1'b0, wptr - raddr};
    if (wptr == raddr) span = (AW+1)'(DEPTH);
  end

  AST_TAP_SPAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_n |-> (span >= (AW+1)'(1)) && (span <= (AW+1)'(LINE_LEN)));  // R1
  AST_TAP_CLAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_n && (tap_i > LAST_TAP)) |-> (span == (AW+1)'(LINE_LEN)));  // R3
  AST_OUT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_n |=> (sample_o == '0));  // R5
  AST_PTR_HOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_n |-> (wptr == '0));  // R5

endmodule

// File: tb/tdl_tap_line_bench.sv
module tdl_tap_line_bench;

  logic       clk = 1'b0;
  logic       rst_ni;
  logic [7:0] sample_i;
  logic [4:0] tap_a;
  logic [3:0] tap_b;
  logic [7:0] out_a;
  logic [7:0] out_b;

  always #2 clk = ~clk;

  tdl_tap_line #(.DATA_W(8), .LINE_LEN(20)) u_tdl_tap_line (
    .clk_i(clk), .rst_ni(rst_ni), .sample_i(sample_i), .tap_i(tap_a), .sample_o(out_a)
  );

  tdl_tap_line #(.DATA_W(8), .LINE_LEN(16)) u_tdl_tap_line_full (
    .clk_i(clk), .rst_ni(rst_ni), .sample_i(sample_i), .tap_i(tap_b), .sample_o(out_b)
  );

  int   nchk = 0;
  int   nerr = 0;
  bit   done = 0;

  logic [7:0] mem_a [32];
  bit         val_a [32];
  int         ptr_a = 0;
  logic [7:0] mem_b [16];
  bit         val_b [16];
  int         ptr_b = 0;

  function automatic int wrap(input int v, input int d);
    return ((v % d) + d) % d;
  endfunction

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic [7:0] s, input logic [4:0] ta, input logic [3:0] tb,
                      input string tag);
    int ca, ia, ib;
    logic [7:0] ea, eb;
    bit va, vb;
    string taga, tagb;
    sample_i = s; tap_a = ta; tap_b = tb;
    ca = (ta > 19) ? 19 : int'(ta);
    ia = wrap(ptr_a - 1 - ca, 32);
    ib = wrap(ptr_b - 1 - int'(tb), 16);
    va = val_a[ia]; ea = mem_a[ia];
    vb = val_b[ib]; eb = mem_b[ib];
    taga = (tag != "") ? tag : ((ta > 19) ? "R3" : "R1");
    tagb = (tag != "") ? tag : ((tb == 15) ? "R7" : "R1");
    @(posedge clk);
    mem_a[ptr_a] = s; val_a[ptr_a] = 1'b1; ptr_a = wrap(ptr_a + 1, 32);
    mem_b[ptr_b] = s; val_b[ptr_b] = 1'b1; ptr_b = wrap(ptr_b + 1, 16);
    @(negedge clk);
    if (va) check(out_a, ea, taga);
    if (vb) check(out_b, eb, tagb);
  endtask

  task automatic do_reset(input int hold);
    rst_ni = 1'b0;
    repeat (hold) @(negedge clk);
    check(out_a, 8'h00, "R5");
    check(out_b, 8'h00, "R5");
    rst_ni = 1'b1;
    repeat (2) begin
      @(posedge clk);
      @(negedge clk);
      check(out_a, 8'h00, "R5");
      check(out_b, 8'h00, "R5");
    end
    ptr_a = 0;
    ptr_b = 0;
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
  endtask

  initial begin
    #800000;
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < 32; i++) val_a[i] = 1'b0;
    for (int i = 0; i < 16; i++) val_b[i] = 1'b0;
    rst_ni = 1'b0; sample_i = '0; tap_a = '0; tap_b = '0;
    @(negedge clk);
    do_reset(3);

    // R1: fill with tap 0, then a sweep of every tap value
    for (int i = 0; i < 40; i++) step(8'(i * 7 + 3), 5'd0, 4'd0, "");
    for (int t = 0; t < 32; t++) step(8'(200 - t), 5'(t), 4'(t), "");

    // R4: whole-byte patterns with lanes that differ from each other
    for (int i = 0; i < 8; i++) step(8'h01 << i, 5'd0, 4'd0, "R4");
    step(8'hFF, 5'd1, 4'd1, "R4");
    step(8'h00, 5'd1, 4'd1, "R4");
    step(8'hA5, 5'd1, 4'd1, "R4");
    step(8'h5A, 5'd1, 4'd1, "R4");

    // R2: random traffic across many wraps
    for (int i = 0; i < 2000; i++)
      step(8'($urandom), 5'($urandom), 4'($urandom), "R2");

    // R3 and R7 corner taps
    for (int i = 0; i < 20; i++) step(8'($urandom), 5'd31, 4'd15, "");
    for (int i = 0; i < 20; i++) step(8'($urandom), 5'd19, 4'd15, "");

    // R6: reset mid-run, old words survive
    @(negedge clk);
    do_reset(2);
    for (int k = 0; k < 10; k++) step(8'(k + 90), 5'(k + 3), 4'(k + 2), "R6");

    for (int i = 0; i < 500; i++)
      step(8'($urandom), 5'($urandom), 4'($urandom), "");

    done = 1;
    summary();
    $finish;
  end

endmodule